// File: doc/BRIEF.md
# Memory-mapped GPIO bank controller

A bank of up to 32 general-purpose lines driven from a 32-bit single-cycle register bus. Each line has one bit in a set of per-line registers. They decide whether the line is plain I/O or feeds a separate interrupt detector, and whether it is an input or an output. They also hold the value it drives, pick where that value comes from, and set the trigger polarity and sensing. The pin side is split into an input vector, an output vector and an output-enable vector, so that a pad ring can sit outside the block.

Software configures a line by read-modify-write of the bit for that line. The output value may be loaded while the line is still an input. The line then drives that value from the first cycle its direction bit turns to output, so no wrong level is ever driven. The interrupt detector is a separate block: this bank only hands it the mode, polarity, trigger and dual-edge bits. Reading the input-data word returns the pins through a two-flop synchronizer, or the stored output value for lines set as outputs.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held and after it is released, every register reads 0, so pin_oe_o, pin_o and all irq_*_o outputs are 0 and each line is a plain input with positive logic.
- R2: A write stores wdata_i into the register at its byte offset, and a read at that offset returns it. The offsets are 0x00 mode, 0x04 direction, 0x08 output data, 0x20 polarity, 0x24 trigger, 0x40 output source and 0x4C dual edge. Bit n always belongs to line n.
- R3: pin_oe_o[n] is 1 exactly when mode bit n is 0 (plain I/O; 1 = interrupt input) and direction bit n is 1 (1 = output, 0 = input). It changes in the cycle after the write that sets these bits.
- R4: pin_o[n] is output-data bit n when source bit n is 0, and alt_out_i[n] when source bit n is 1. Output data written while the line is an input is already on pin_o, so the first cycle with pin_oe_o[n] high drives the stored value.
- R5: A read at offset 0x0C returns, for each input line (direction bit 0), the level of pin_i as it was two rising clock edges earlier.
- R6: A read at offset 0x0C returns the output-data bit for each line whose direction bit is 1, whatever the pin level.
- R7: Writes to 0x0C and to unmapped offsets change no register. Reads at unmapped offsets, including any address with bits [1:0] nonzero, return 0.
- R8: irq_mode_o, irq_pol_o, irq_trig_o and irq_both_o equal the mode, polarity (1 = negative), trigger (1 = edge, 0 = level) and dual-edge (1 = both edges) registers.
- R9: rdata_o is 0 in any cycle that is not a read (valid_i low or write_i high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Bus access this cycle |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| pin_i | input | NUM_LINES | Pad input levels |
| alt_out_i | input | NUM_LINES | Alternate output data source |
| pin_o | output | NUM_LINES | Pad output levels |
| pin_oe_o | output | NUM_LINES | Pad output enables |
| irq_mode_o | output | NUM_LINES | Line is in interrupt-input mode |
| irq_pol_o | output | NUM_LINES | Negative-logic select to detector |
| irq_trig_o | output | NUM_LINES | Edge-sense select to detector |
| irq_both_o | output | NUM_LINES | Both-edge select to detector |

## Verification
Two functions can fall in the same cycle. A line's output-data bit can be written while it is still an input, and its direction is flipped to output in the very next write. The directed case loads the value, checks that pin_o already carries it while pin_oe_o is low, and then checks that the first enabled cycle drives it. The same check runs for both levels. The input readback also depends on the direction bit and the pin history together. Random passes change the pins and the direction word in the same iteration, and every line of the 0x0C read is judged against the direction in force.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 7;

  localparam logic [ADDR_W-1:0] OFS_MODE = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 7'h08;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 7'h0C;
  localparam logic [ADDR_W-1:0] OFS_POL  = 7'h20;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 7'h24;
  localparam logic [ADDR_W-1:0] OFS_SRC  = 7'h40;
  localparam logic [ADDR_W-1:0] OFS_BOTH = 7'h4C;

  typedef struct packed {
    logic [BUS_W-1:0] mode;
    logic [BUS_W-1:0] dir;
    logic [BUS_W-1:0] dout;
    logic [BUS_W-1:0] pol;
    logic [BUS_W-1:0] trig;
    logic [BUS_W-1:0] src;
    logic [BUS_W-1:0] both;
  } gpio_cfg_t;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES     = 32,
  parameter bit          HAS_SRC_SEL   = 1'b1,
  parameter bit          HAS_BOTH_EDGE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output gpio_cfg_t         cfg_o
);
  localparam logic [BUS_W-1:0] LINE_MASK =
    (NUM_LINES >= BUS_W) ? {BUS_W{1'b1}} : BUS_W'((64'd1 << NUM_LINES) - 64'd1);

  logic [BUS_W-1:0] wval;
  assign wval = wdata_i & LINE_MASK;

  logic [BUS_W-1:0] mode_q, dir_q, dout_q, pol_q, trig_q, src_q, both_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFS_MODE: mode_q <= wval;
        OFS_DIR:  dir_q  <= wval;
        OFS_DOUT: dout_q <= wval;
        OFS_POL:  pol_q  <= wval;
        OFS_TRIG: trig_q <= wval;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_SRC_SEL) begin : g_src
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) src_q <= '0;
        else if (wr_en_i && addr_i == OFS_SRC) src_q <= wval;
      end
    end else begin : g_no_src
      assign src_q = '0;
    end

    if (HAS_BOTH_EDGE) begin : g_both
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) both_q <= '0;
        else if (wr_en_i && addr_i == OFS_BOTH) both_q <= wval;
      end
    end else begin : g_no_both
      assign both_q = '0;
    end
  endgenerate

  assign cfg_o = '{mode: mode_q, dir: dir_q, dout: dout_q, pol: pol_q,
                   trig: trig_q, src: src_q, both: both_q};
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] sync_o
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= pin_i[n];
        stab_q <= meta_q;
      end
    end
    assign sync_o[n] = stab_q;
  end
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  gpio_cfg_t            cfg_i,
  input  logic [NUM_LINES-1:0] sync_i,
  output logic [BUS_W-1:0]     rdata_o
);
  logic [BUS_W-1:0] sync_ext, din_word;

  assign sync_ext = BUS_W'(sync_i);
  // output lines report the stored value, not the pad
  assign din_word = (cfg_i.dir & cfg_i.dout) | (~cfg_i.dir & sync_ext);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        OFS_MODE: rdata_o = cfg_i.mode;
        OFS_DIR:  rdata_o = cfg_i.dir;
        OFS_DOUT: rdata_o = cfg_i.dout;
        OFS_DIN:  rdata_o = din_word;
        OFS_POL:  rdata_o = cfg_i.pol;
        OFS_TRIG: rdata_o = cfg_i.trig;
        OFS_SRC:  rdata_o = cfg_i.src;
        OFS_BOTH: rdata_o = cfg_i.both;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES     = 32,
  parameter bit          HAS_SRC_SEL   = 1'b1,
  parameter bit          HAS_BOTH_EDGE = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 write_i,
  input  logic [6:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [NUM_LINES-1:0] alt_out_i,
  output logic [NUM_LINES-1:0] pin_o,
  output logic [NUM_LINES-1:0] pin_oe_o,
  output logic [NUM_LINES-1:0] irq_mode_o,
  output logic [NUM_LINES-1:0] irq_pol_o,
  output logic [NUM_LINES-1:0] irq_trig_o,
  output logic [NUM_LINES-1:0] irq_both_o
);
  gpio_cfg_t             cfg;
  logic [NUM_LINES-1:0]  pin_sync;
  logic [NUM_LINES-1:0]  mode_l, dir_l, dout_l, src_l;

  gpio_bank_regs #(
    .NUM_LINES(NUM_LINES), .HAS_SRC_SEL(HAS_SRC_SEL), .HAS_BOTH_EDGE(HAS_BOTH_EDGE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(valid_i && write_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cfg_o(cfg)
  );

  gpio_bank_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .sync_o(pin_sync)
  );

  gpio_bank_rdmux #(.NUM_LINES(NUM_LINES)) u_rdmux (
    .rd_en_i(valid_i && !write_i), .addr_i(addr_i), .cfg_i(cfg),
    .sync_i(pin_sync), .rdata_o(rdata_o)
  );

  assign mode_l = cfg.mode[NUM_LINES-1:0];
  assign dir_l  = cfg.dir[NUM_LINES-1:0];
  assign dout_l = cfg.dout[NUM_LINES-1:0];
  assign src_l  = cfg.src[NUM_LINES-1:0];

  // data path is live regardless of enable: no glitch on direction switch
  assign pin_o      = (src_l & alt_out_i) | (~src_l & dout_l);
  assign pin_oe_o   = ~mode_l & dir_l;
  assign irq_mode_o = mode_l;
  assign irq_pol_o  = cfg.pol[NUM_LINES-1:0];
  assign irq_trig_o = cfg.trig[NUM_LINES-1:0];
  assign irq_both_o = cfg.both[NUM_LINES-1:0];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 write_i,
  input logic [6:0]           addr_i,
  input logic [31:0]          wdata_i,
  input logic [31:0]          rdata_o,
  input logic [NUM_LINES-1:0] pin_i,
  input logic [NUM_LINES-1:0] alt_out_i,
  input logic [NUM_LINES-1:0] pin_o,
  input logic [NUM_LINES-1:0] pin_oe_o,
  input logic [NUM_LINES-1:0] irq_mode_o,
  input logic [NUM_LINES-1:0] irq_pol_o,
  input logic [NUM_LINES-1:0] irq_trig_o,
  input logic [NUM_LINES-1:0] irq_both_o
);
  logic mapped;
  assign mapped = addr_i inside {OFS_MODE, OFS_DIR, OFS_DOUT, OFS_DIN,
                                 OFS_POL, OFS_TRIG, OFS_SRC, OFS_BOTH};

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_oe_o == '0 && irq_mode_o == '0));

  p_oe_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i && addr_i == OFS_DIR)
      |=> pin_oe_o == ($past(wdata_i[NUM_LINES-1:0]) & ~irq_mode_o));

  p_mode_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i && addr_i == OFS_MODE)
      |=> irq_mode_o == $past(wdata_i[NUM_LINES-1:0]));

  p_unmapped_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !write_i && !mapped) |-> rdata_o == '0);

  p_ro_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i && (addr_i == OFS_DIN || !mapped))
      |=> ($stable(pin_oe_o) && $stable(irq_mode_o) && $stable(irq_pol_o)));

  p_idle_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && !write_i) |-> rdata_o == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, write = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pin_in = '0, alt = '0;
  logic [N-1:0] pin_out, pin_oe, i_mode, i_pol, i_trig, i_both;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_mode = 0, m_dir = 0, m_dout = 0, m_pol = 0, m_trig = 0, m_src = 0, m_both = 0;

  always #10 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .write_i(write), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .alt_out_i(alt),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_mode_o(i_mode), .irq_pol_o(i_pol),
    .irq_trig_o(i_trig), .irq_both_o(i_both)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [6:0] a);
    case (a)
      7'h00: return m_mode;
      7'h04: return m_dir;
      7'h08: return m_dout;
      7'h0C: return (m_dir & m_dout) | (~m_dir & pin_in);
      7'h20: return m_pol;
      7'h24: return m_trig;
      7'h40: return m_src;
      7'h4C: return m_both;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_pin();
    return (m_src & alt) | (~m_src & m_dout);
  endfunction

  task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    case (a)
      7'h00: m_mode = d;
      7'h04: m_dir = d;
      7'h08: m_dout = d;
      7'h20: m_pol = d;
      7'h24: m_trig = d;
      7'h40: m_src = d;
      7'h4C: m_both = d;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [6:0] a, input string req);
    valid = 1'b1; write = 1'b0; addr = a;
    #1;
    chk(req, $sformatf("read @%h", a), rdata, exp_read(a));
    valid = 1'b0;
    #1;
  endtask

  task automatic chk_outputs(input string req);
    chk(req, "pin_oe_o", pin_oe, ~m_mode & m_dir);
    chk(req, "pin_o", pin_out, exp_pin());
    chk("R8", "irq_mode_o", i_mode, m_mode);
    chk("R8", "irq_pol_o", i_pol, m_pol);
    chk("R8", "irq_trig_o", i_trig, m_trig);
    chk("R8", "irq_both_o", i_both, m_both);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #5;
    // R1: outputs during reset
    chk("R1", "oe in reset", pin_oe, '0);
    chk("R1", "rdata idle in reset", rdata, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outputs("R1");
    foreach (exp_read_list[k]) bus_rd(exp_read_list[k], "R1");

    // R9: idle bus and writes give 0 read data
    bus_wr(7'h08, 32'hA5A5_0F0F);
    chk("R9", "rdata idle", rdata, '0);
    valid = 1'b1; write = 1'b1; addr = 7'h08; #1;
    chk("R9", "rdata during write", rdata, '0);
    valid = 1'b0; write = 1'b0;

    // R4: stored value already on pin_o before the line is enabled, both levels
    chk("R4", "pin_o before enable", pin_out, 32'hA5A5_0F0F);
    chk("R3", "oe still off", pin_oe, '0);
    bus_wr(7'h04, 32'hFFFF_FFFF);
    chk("R4", "first enabled cycle drives stored", pin_out, 32'hA5A5_0F0F);
    chk("R3", "oe after dir", pin_oe, 32'hFFFF_FFFF);
    // R6: readback of outputs ignores the pad
    pin_in = 32'h1234_5678; repeat (2) @(negedge clk);
    bus_rd(7'h0C, "R6");
    bus_wr(7'h04, 32'h0);
    bus_wr(7'h08, 32'h5A5A_F0F0);
    chk("R4", "pin_o preload second level", pin_out, 32'h5A5A_F0F0);
    bus_wr(7'h04, 32'h0000_FFFF);
    chk("R4", "partial enable drives preload", pin_out, 32'h5A5A_F0F0);
    chk("R3", "partial oe", pin_oe, 32'h0000_FFFF);

    // R3: interrupt mode suppresses enable
    bus_wr(7'h00, 32'h0000_00FF);
    chk("R3", "mode blocks oe", pin_oe, 32'h0000_FF00);
    bus_wr(7'h00, 32'h0);

    // R4: alternate source
    alt = 32'hDEAD_BEEF;
    bus_wr(7'h40, 32'hFF00_FF00);
    chk("R4", "source select", pin_out, exp_pin());

    // R5: synchronizer latency of two edges
    bus_wr(7'h04, 32'h0);
    pin_in = 32'h0;
    repeat (3) @(negedge clk);
    pin_in = 32'hCAFE_F00D;
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = 7'h0C; #1;
    chk("R5", "one edge: old value", rdata, 32'h0);
    valid = 1'b0;
    @(negedge clk);
    bus_rd(7'h0C, "R5");

    // R7: read-only and unmapped writes, misaligned reads
    bus_wr(7'h0C, 32'hFFFF_FFFF);
    bus_wr(7'h10, 32'hFFFF_FFFF);
    bus_wr(7'h01, 32'hFFFF_FFFF);
    chk_outputs("R7");
    bus_rd(7'h10, "R7");
    bus_rd(7'h05, "R7");
    bus_rd(7'h7C, "R7");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      logic [6:0] a;
      sel = int'($urandom % 10);
      case (sel)
        0: a = 7'h00; 1: a = 7'h04; 2: a = 7'h08; 3: a = 7'h0C;
        4: a = 7'h20; 5: a = 7'h24; 6: a = 7'h40; 7: a = 7'h4C;
        8: a = {$urandom % 32, 2'b00};
        default: a = 7'($urandom);
      endcase
      if ($urandom % 3 == 0) pin_in = $urandom;
      alt = $urandom;
      bus_wr(a, $urandom);
      repeat (2) @(negedge clk);
      chk_outputs("R2");
      bus_rd(a, "R2");
      bus_rd(7'h0C, "R5");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [6:0] exp_read_list [8] = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h20, 7'h24, 7'h40, 7'h4C};
endmodule